// File: doc/BRIEF.md
# Per-Issue Fault Commit Suppressor

This block sits at the end of the execute stage of a multi-issue processor. Each issue has a small group of function units, and each unit has a current-sensor fault flag. Each issue also reports which of its units its instruction actually used, with one bit per unit. In each cycle the block checks, for every issue, whether the unit in use was flagged. If it was, the result of that issue is not committed. The block passes a fixed no-operation value in place of the computed result and clears the issue's register write enable and memory write enable.

A fault flag on a unit that the issue did not use does not stop the commit. This lets healthy parts of a partly faulty issue keep working. A flagged instruction is not thrown away: its encoding is held in a replay shadow register, marked valid for one cycle, so a scheduler can issue it again. A summary new-fault line tells that scheduler that at least one lane was blocked in that cycle. Fault flags are transient. Once a flag clears, the unit takes part again at once, and the block keeps no sticky fault state.

Top module: `fault_commit_guard`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, every output is zero: results, both enables, `sup_mask`, `new_fault`, `replay_valid` and `replay_instr`.
- R2: Lane i counts as hit when `ex_valid[i]` is 1 and some bit u has both `ex_unit_sel[i*UNITS+u]` and `ex_fault[i*UNITS+u]` set. `sup_mask[i]` equals that hit value one clock after the inputs are sampled.
- R3: A fault flag on a unit whose `ex_unit_sel` bit is 0, or on a lane whose `ex_valid` is 0, does not suppress the lane. That lane's result and enables still pass through.
- R4: The result of a suppressed lane (lane i in `cm_result[i*DATA_W +: DATA_W]`) is `NOP_RESULT`, which is zero by default.
- R5: A suppressed lane has `cm_wb_en[i]` and `cm_mem_en[i]` both at 0.
- R6: An unsuppressed lane outputs, one clock later, the `ex_result`, `ex_wb_en` and `ex_mem_en` values it was given.
- R7: `new_fault` is 1 exactly in the cycles in which at least one bit of `sup_mask` is 1.
- R8: `replay_valid` equals `sup_mask`. For each suppressed lane, `replay_instr[i*INSTR_W +: INSTR_W]` holds that lane's `ex_instr` from the faulting cycle.
- R9: Suppression has no memory. Once a flag clears, the next cycle's commit for that lane depends only on its new inputs.
- R10: The replay slot of a lane that is not suppressed keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | ISSUES | Lane carries an instruction this cycle |
| ex_unit_sel | input | ISSUES*UNITS | Unit used by each lane's instruction |
| ex_fault | input | ISSUES*UNITS | Sensor fault flag per unit |
| ex_result | input | ISSUES*DATA_W | Computed result per lane |
| ex_wb_en | input | ISSUES | Register write enable per lane |
| ex_mem_en | input | ISSUES | Memory write enable per lane |
| ex_instr | input | ISSUES*INSTR_W | Executed instruction word per lane |
| cm_result | output | ISSUES*DATA_W | Committed result per lane |
| cm_wb_en | output | ISSUES | Committed register write enable |
| cm_mem_en | output | ISSUES | Committed memory write enable |
| sup_mask | output | ISSUES | Lane result suppressed |
| new_fault | output | 1 | At least one lane suppressed |
| replay_valid | output | ISSUES | Replay slot holds a fresh faulty instruction |
| replay_instr | output | ISSUES*INSTR_W | Captured instructions for replay |

## Verification
Every output passes through exactly one register, so each result is due on the first rising edge after its inputs are applied. The bench drives inputs on the falling edge. It then waits one rising edge and samples on the next falling edge, so each comparison uses the inputs that are still on the pins. The expected replay contents are tracked across cycles in the bench, because a lane that is not hit must keep whatever was captured in it earlier.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int unsigned FCG_MAX_UNITS = 32;

  // True when any used unit is also flagged faulty.
  function automatic logic unit_hit(input logic [FCG_MAX_UNITS-1:0] used,
                                    input logic [FCG_MAX_UNITS-1:0] flt);
    return |(used & flt);
  endfunction
endpackage

// File: rtl/fcg_fault_lane.sv
module fcg_fault_lane #(
  parameter int unsigned UNITS = 2
) (
  input  logic             valid,
  input  logic [UNITS-1:0] used,
  input  logic [UNITS-1:0] flt,
  output logic             hit
);
  import fcg_pkg::*;

  localparam int unsigned PADW = FCG_MAX_UNITS - UNITS;

  always_comb begin
    hit = valid & unit_hit({{PADW{1'b0}}, used}, {{PADW{1'b0}}, flt});
  end
endmodule

// File: rtl/fcg_commit_lane.sv
module fcg_commit_lane #(
  parameter int unsigned          DATA_W     = 32,
  parameter logic [DATA_W-1:0]    NOP_RESULT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [DATA_W-1:0] res_in,
  input  logic              wb_in,
  input  logic              mem_in,
  output logic [DATA_W-1:0] res_out,
  output logic              wb_out,
  output logic              mem_out,
  output logic              sup_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
      wb_out  <= 1'b0;
      mem_out <= 1'b0;
      sup_out <= 1'b0;
    end else begin
      sup_out <= hit;
      res_out <= hit ? NOP_RESULT : res_in;
      wb_out  <= wb_in & ~hit;
      mem_out <= mem_in & ~hit;
    end
  end
endmodule

// File: rtl/fcg_replay_shadow.sv
module fcg_replay_shadow #(
  parameter int unsigned ISSUES  = 4,
  parameter int unsigned INSTR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ISSUES-1:0]           load,
  input  logic [ISSUES*INSTR_W-1:0]   instr_in,
  output logic [ISSUES-1:0]           slot_valid,
  output logic [ISSUES*INSTR_W-1:0]   slot_instr
);
  for (genvar g = 0; g < ISSUES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_valid[g] <= 1'b0;
        slot_instr[g*INSTR_W +: INSTR_W] <= '0;
      end else begin
        slot_valid[g] <= load[g];
        if (load[g]) slot_instr[g*INSTR_W +: INSTR_W] <= instr_in[g*INSTR_W +: INSTR_W];
      end
    end
  end
endmodule

// File: rtl/fault_commit_guard.sv
module fault_commit_guard #(
  parameter int unsigned          ISSUES     = 4,
  parameter int unsigned          UNITS      = 2,
  parameter int unsigned          DATA_W     = 32,
  parameter int unsigned          INSTR_W    = 32,
  parameter logic [DATA_W-1:0]    NOP_RESULT = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ISSUES-1:0]          ex_valid,
  input  logic [ISSUES*UNITS-1:0]    ex_unit_sel,
  input  logic [ISSUES*UNITS-1:0]    ex_fault,
  input  logic [ISSUES*DATA_W-1:0]   ex_result,
  input  logic [ISSUES-1:0]          ex_wb_en,
  input  logic [ISSUES-1:0]          ex_mem_en,
  input  logic [ISSUES*INSTR_W-1:0]  ex_instr,
  output logic [ISSUES*DATA_W-1:0]   cm_result,
  output logic [ISSUES-1:0]          cm_wb_en,
  output logic [ISSUES-1:0]          cm_mem_en,
  output logic [ISSUES-1:0]          sup_mask,
  output logic                       new_fault,
  output logic [ISSUES-1:0]          replay_valid,
  output logic [ISSUES*INSTR_W-1:0]  replay_instr
);
  logic [ISSUES-1:0] lane_hit;

  for (genvar g = 0; g < ISSUES; g++) begin : g_lane
    fcg_fault_lane #(.UNITS(UNITS)) u_detect (
      .valid (ex_valid[g]),
      .used  (ex_unit_sel[g*UNITS +: UNITS]),
      .flt   (ex_fault[g*UNITS +: UNITS]),
      .hit   (lane_hit[g])
    );

    fcg_commit_lane #(.DATA_W(DATA_W), .NOP_RESULT(NOP_RESULT)) u_commit (
      .clk     (clk),
      .rst     (rst),
      .hit     (lane_hit[g]),
      .res_in  (ex_result[g*DATA_W +: DATA_W]),
      .wb_in   (ex_wb_en[g]),
      .mem_in  (ex_mem_en[g]),
      .res_out (cm_result[g*DATA_W +: DATA_W]),
      .wb_out  (cm_wb_en[g]),
      .mem_out (cm_mem_en[g]),
      .sup_out (sup_mask[g])
    );
  end

  fcg_replay_shadow #(.ISSUES(ISSUES), .INSTR_W(INSTR_W)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .load       (lane_hit),
    .instr_in   (ex_instr),
    .slot_valid (replay_valid),
    .slot_instr (replay_instr)
  );

  always_ff @(posedge clk) begin
    if (rst) new_fault <= 1'b0;
    else     new_fault <= |lane_hit;
  end
endmodule

// File: rtl/fcg_guard_chk.sv
module fcg_guard_chk #(
  parameter int unsigned          ISSUES     = 4,
  parameter int unsigned          UNITS      = 2,
  parameter int unsigned          DATA_W     = 32,
  parameter int unsigned          INSTR_W    = 32,
  parameter logic [DATA_W-1:0]    NOP_RESULT = '0
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ISSUES-1:0]          ex_valid,
  input logic [ISSUES*UNITS-1:0]    ex_unit_sel,
  input logic [ISSUES*UNITS-1:0]    ex_fault,
  input logic [ISSUES*DATA_W-1:0]   ex_result,
  input logic [ISSUES-1:0]          ex_wb_en,
  input logic [ISSUES-1:0]          ex_mem_en,
  input logic [ISSUES*INSTR_W-1:0]  ex_instr,
  input logic [ISSUES*DATA_W-1:0]   cm_result,
  input logic [ISSUES-1:0]          cm_wb_en,
  input logic [ISSUES-1:0]          cm_mem_en,
  input logic [ISSUES-1:0]          sup_mask,
  input logic                       new_fault,
  input logic [ISSUES-1:0]          replay_valid,
  input logic [ISSUES*INSTR_W-1:0]  replay_instr
);
  // R7
  new_fault_match_chk: assert property (@(posedge clk) disable iff (rst)
    new_fault == (sup_mask != '0));

  // R8
  replay_flag_chk: assert property (@(posedge clk) disable iff (rst)
    replay_valid == sup_mask);

  for (genvar g = 0; g < ISSUES; g++) begin : g_lane_chk
    // R2
    hit_suppress_chk: assert property (@(posedge clk) disable iff (rst)
      (ex_valid[g] && ((ex_unit_sel[g*UNITS +: UNITS] & ex_fault[g*UNITS +: UNITS]) != '0))
      |=> sup_mask[g]);

    // R3
    idle_fault_pass_chk: assert property (@(posedge clk) disable iff (rst)
      !(ex_valid[g] && ((ex_unit_sel[g*UNITS +: UNITS] & ex_fault[g*UNITS +: UNITS]) != '0))
      |=> !sup_mask[g]);

    // R4
    nop_result_chk: assert property (@(posedge clk) disable iff (rst)
      sup_mask[g] |-> cm_result[g*DATA_W +: DATA_W] == NOP_RESULT);

    // R5
    enables_off_chk: assert property (@(posedge clk) disable iff (rst)
      sup_mask[g] |-> (!cm_wb_en[g] && !cm_mem_en[g]));

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
      !(ex_valid[g] && ((ex_unit_sel[g*UNITS +: UNITS] & ex_fault[g*UNITS +: UNITS]) != '0))
      |=> (cm_result[g*DATA_W +: DATA_W] == $past(ex_result[g*DATA_W +: DATA_W]))
          && (cm_wb_en[g] == $past(ex_wb_en[g])) && (cm_mem_en[g] == $past(ex_mem_en[g])));

    // R8
    replay_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (ex_valid[g] && ((ex_unit_sel[g*UNITS +: UNITS] & ex_fault[g*UNITS +: UNITS]) != '0))
      |=> replay_instr[g*INSTR_W +: INSTR_W] == $past(ex_instr[g*INSTR_W +: INSTR_W]));
  end
endmodule

bind fault_commit_guard fcg_guard_chk #(
  .ISSUES(ISSUES), .UNITS(UNITS), .DATA_W(DATA_W), .INSTR_W(INSTR_W), .NOP_RESULT(NOP_RESULT)
) u_chk (.*);

// File: tb/fault_commit_guard_tb.sv
`timescale 1ns/1ps
module fault_commit_guard_tb;
  localparam int unsigned ISSUES  = 4;
  localparam int unsigned UNITS   = 2;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned INSTR_W = 32;

  logic clk = 1'b0;
  logic rst;
  logic [ISSUES-1:0]         ex_valid;
  logic [ISSUES*UNITS-1:0]   ex_unit_sel;
  logic [ISSUES*UNITS-1:0]   ex_fault;
  logic [ISSUES*DATA_W-1:0]  ex_result;
  logic [ISSUES-1:0]         ex_wb_en;
  logic [ISSUES-1:0]         ex_mem_en;
  logic [ISSUES*INSTR_W-1:0] ex_instr;
  logic [ISSUES*DATA_W-1:0]  cm_result;
  logic [ISSUES-1:0]         cm_wb_en;
  logic [ISSUES-1:0]         cm_mem_en;
  logic [ISSUES-1:0]         sup_mask;
  logic                      new_fault;
  logic [ISSUES-1:0]         replay_valid;
  logic [ISSUES*INSTR_W-1:0] replay_instr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [INSTR_W-1:0] exp_slot [ISSUES];

  always #2.5 clk = ~clk;

  fault_commit_guard #(.ISSUES(ISSUES), .UNITS(UNITS), .DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_dut (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_unit_sel(ex_unit_sel), .ex_fault(ex_fault),
    .ex_result(ex_result), .ex_wb_en(ex_wb_en), .ex_mem_en(ex_mem_en), .ex_instr(ex_instr),
    .cm_result(cm_result), .cm_wb_en(cm_wb_en), .cm_mem_en(cm_mem_en), .sup_mask(sup_mask),
    .new_fault(new_fault), .replay_valid(replay_valid), .replay_instr(replay_instr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive lane i from a 5-bit code: [0]=valid, [2:1]=unit used, [4:3]=fault flags.
  task automatic drive_lane(input int i, input logic [4:0] code);
    ex_valid[i] = code[0];
    ex_unit_sel[i*UNITS +: UNITS] = code[2:1];
    ex_fault[i*UNITS +: UNITS] = code[4:3];
    ex_result[i*DATA_W +: DATA_W] = $urandom;
    ex_instr[i*INSTR_W +: INSTR_W] = $urandom;
    ex_wb_en[i] = 1'($urandom);
    ex_mem_en[i] = 1'($urandom);
  endtask

  // Called at the falling edge after the clocking edge; inputs still held.
  task automatic check_cycle(input string tag);
    logic any_hit;
    any_hit = 1'b0;
    for (int i = 0; i < ISSUES; i++) begin
      logic h;
      h = ex_valid[i] && ((ex_unit_sel[i*UNITS +: UNITS] & ex_fault[i*UNITS +: UNITS]) != 0);
      any_hit |= h;
      if (h) exp_slot[i] = ex_instr[i*INSTR_W +: INSTR_W];
      chk(sup_mask[i] == h, {tag, " R2/R3 sup_mask"}, 64'(sup_mask[i]), 64'(h));
      if (h) begin
        chk(cm_result[i*DATA_W +: DATA_W] == '0, {tag, " R4 nop result"},
            64'(cm_result[i*DATA_W +: DATA_W]), 64'd0);
        chk(!cm_wb_en[i] && !cm_mem_en[i], {tag, " R5 enables"},
            64'({cm_wb_en[i], cm_mem_en[i]}), 64'd0);
        chk(replay_instr[i*INSTR_W +: INSTR_W] == exp_slot[i], {tag, " R8 replay capture"},
            64'(replay_instr[i*INSTR_W +: INSTR_W]), 64'(exp_slot[i]));
      end else begin
        chk(cm_result[i*DATA_W +: DATA_W] == ex_result[i*DATA_W +: DATA_W], {tag, " R6 result pass"},
            64'(cm_result[i*DATA_W +: DATA_W]), 64'(ex_result[i*DATA_W +: DATA_W]));
        chk(cm_wb_en[i] == ex_wb_en[i] && cm_mem_en[i] == ex_mem_en[i], {tag, " R6 enables pass"},
            64'({cm_wb_en[i], cm_mem_en[i]}), 64'({ex_wb_en[i], ex_mem_en[i]}));
        chk(replay_instr[i*INSTR_W +: INSTR_W] == exp_slot[i], {tag, " R10 replay held"},
            64'(replay_instr[i*INSTR_W +: INSTR_W]), 64'(exp_slot[i]));
      end
      chk(replay_valid[i] == h, {tag, " R8 replay_valid"}, 64'(replay_valid[i]), 64'(h));
    end
    chk(new_fault == any_hit, {tag, " R7 new_fault"}, 64'(new_fault), 64'(any_hit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    ex_valid = '1; ex_unit_sel = '1; ex_fault = '1; ex_result = '1;
    ex_wb_en = '1; ex_mem_en = '1; ex_instr = '1;
    for (int i = 0; i < ISSUES; i++) exp_slot[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while inputs all show faults
    chk(cm_result == '0 && cm_wb_en == '0 && cm_mem_en == '0, "R1 reset commit",
        64'({cm_wb_en, cm_mem_en}), 64'd0);
    chk(sup_mask == '0 && !new_fault, "R1 reset sup", 64'({sup_mask, new_fault}), 64'd0);
    chk(replay_valid == '0 && replay_instr == '0, "R1 reset replay", 64'(replay_instr), 64'd0);
    rst = 1'b0;

    // Sweep all codes for lanes 0/1; lanes 2/3 get scrambled copies.
    for (int p = 0; p < 1024; p++) begin
      logic [9:0] pv;
      pv = 10'(p);
      drive_lane(0, pv[4:0]);
      drive_lane(1, pv[9:5]);
      drive_lane(2, pv[4:0] ^ 5'b10110);
      drive_lane(3, pv[9:5] ^ 5'b01011);
      @(posedge clk);
      @(negedge clk);
      check_cycle("sweep");
    end

    // R9: all lanes faulted on their used unit, then flags clear.
    for (int i = 0; i < ISSUES; i++) drive_lane(i, 5'b01011);
    @(posedge clk); @(negedge clk);
    check_cycle("R9 fault");
    for (int i = 0; i < ISSUES; i++) drive_lane(i, 5'b00011);
    @(posedge clk); @(negedge clk);
    check_cycle("R9 cleared");
    chk(sup_mask == '0, "R9 no sticky", 64'(sup_mask), 64'd0);

    // R3: flag only on the idle unit of every lane.
    for (int i = 0; i < ISSUES; i++) drive_lane(i, 5'b10011);
    @(posedge clk); @(negedge clk);
    check_cycle("R3 idle unit");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule